// File: doc/BRIEF.md
# I2C Byte Buffer with Threshold Status

This block holds the byte buffers of an I2C master controller. The CPU side writes bytes into an 8-deep transmit queue and reads bytes out of an 8-deep receive queue. The bus engine takes transmit bytes from the head of one queue and delivers received bytes into the tail of the other.

A single 16-bit configuration word sets a fill threshold for each direction, stored as the value minus one. The same word holds a clear strobe for each queue and a DMA enable for each direction. From the queue fill levels, the transfer byte count and the number of bytes the engine has already taken, the block produces:

- transmit-ready and receive-ready flags, with DMA requests gated by the enables;
- a transmit drain state, used near the end of a transfer, which reports how many bytes remain;
- sticky flags for transmit overflow, transmit underflow and receive overrun.

The status flags are registered. Each one reflects the buffer state one clock after that state changes. Register decoding and the bus engine sit outside this block.

Top module: `i2c_fifo_buf`

## Requirements
- R1: After synchronous reset both queues are empty. `tx_avail`, every status flag, every DMA request and every error flag are low. Both thresholds are 1 and both DMA enables are off.
- R2: A write of `cfg_word` is decoded bit by bit:
  - bits 5:0 hold the transmit threshold minus one;
  - bit 7 is the transmit DMA enable;
  - bits 13:8 hold the receive threshold minus one;
  - bit 15 is the receive DMA enable.

  The new thresholds govern the flags from the next clock on.
- R3: A configuration write with bit 6 set empties the transmit queue, resets the count of bytes taken to zero and clears `tx_overflow`. A write with bit 14 set empties the receive queue and clears `rx_overrun`.
- R4: A change of `xmit_mode` empties the queue of the newly selected direction: 0 to 1 empties the transmit queue, 1 to 0 empties the receive queue. The other queue is left as it was.
- R5: While `xmit_mode` is 1 and the transmit fill is at or below the transmit threshold, `tx_ready` is 1 and `tx_drain` is 0 on the following clock.
- R6: While `xmit_mode` is 1, the fill is above the threshold, and `xfer_count` minus bytes taken (0 if negative) is below the threshold: `tx_ready` becomes 0, `tx_drain` becomes 1 and `drain_count` shows that remaining count. If neither R5 nor R6 applies, both flags keep their values.
- R7: While `xmit_mode` is 0, `tx_ready` and `tx_drain` are 0 on the following clock.
- R8: `rx_ready` is 1 exactly when, on the previous clock, the receive fill exceeded the receive threshold. This holds in either mode.
- R9: `tx_dma_req` equals `tx_ready` when transmit DMA is enabled and is 0 otherwise. `rx_dma_req` relates to `rx_ready` in the same way.
- R10: Both queues are first-in first-out. `eng_tx_data` shows the oldest transmit byte and `cpu_rdata` shows the oldest receive byte.
- R11: A CPU push into a full transmit queue with no engine take in the same cycle stores nothing and sets `tx_overflow`. The flag stays set until a transmit clear.
- R12: A received byte arriving at a full receive queue with no CPU pop in the same cycle is dropped and sets `rx_overrun`. Any CPU pop clears the flag.
- R13: An engine request on an empty transmit queue takes nothing and sets `tx_underflow`. A CPU push clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_word | input | 16 | Configuration word |
| xmit_mode | input | 1 | 1 = transmit transfer, 0 = receive transfer |
| xfer_count | input | 16 | Bytes in the current transfer |
| cpu_push | input | 1 | CPU writes a byte to the transmit queue |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_pop | input | 1 | CPU takes a byte from the receive queue |
| cpu_rdata | output | 8 | Oldest receive byte |
| eng_tx_req | input | 1 | Engine takes a transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_ready | output | 1 | Transmit-ready flag |
| tx_drain | output | 1 | Transmit drain flag |
| rx_ready | output | 1 | Receive-ready flag |
| drain_count | output | 6 | Bytes remaining in the transfer while draining |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_overflow | output | 1 | Transmit push into full queue |
| tx_underflow | output | 1 | Engine request on empty queue |
| rx_overrun | output | 1 | Received byte dropped |

## Verification
The hardest situation to reach is the drain state. It needs three things at once: a transmit fill above the threshold, a remaining transfer count below that threshold, and `tx_ready` holding its old value when neither condition applies.

The bench reaches it by sweeping every transmit threshold from 1 to 8 against several small transfer counts. For each pair it fills the queue one byte past full and then drains it one byte past empty. A model in the bench applies the set, clear and hold rule after every step.

The receive side is swept the same way across all thresholds. Directed steps then cover direction changes and the clearing of the underflow flag.

// File: rtl/i2c_fifo_buf_pkg.sv
package i2c_fifo_buf_pkg;
    localparam int BYTE_W = 8;
    localparam int LVL_W  = 6;
    localparam int CFG_W  = 16;

    typedef struct packed {
        logic             rx_dma;
        logic             rx_clr;
        logic [LVL_W-1:0] rx_lvl;
        logic             tx_dma;
        logic             tx_clr;
        logic [LVL_W-1:0] tx_lvl;
    } buf_cfg_t;

    typedef struct packed {
        logic tx_ready;
        logic tx_drain;
        logic rx_ready;
    } buf_flags_t;

    function automatic logic [LVL_W:0] lvl_to_thr(input logic [LVL_W-1:0] f);
        return {1'b0, f} + (LVL_W+1)'(1);
    endfunction
endpackage

// File: rtl/i2c_fifo_buf_queue.sv
module i2c_fifo_buf_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [FW-1:0]    fill
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (fill == '0);
    assign full    = (fill == FW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + FW'(1);
                2'b01:   fill <= fill - FW'(1);
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // R11 / R12: a push into a full queue without a pop leaves the fill unchanged
    p_full_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (fill == FW'(DEPTH)));
    // R13: a pop on an empty queue leaves it empty
    p_empty_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/i2c_fifo_buf_status.sv
module i2c_fifo_buf_status
    import i2c_fifo_buf_pkg::*;
#(
    parameter int FILL_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xmit_mode,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [LVL_W:0]    tx_thr,
    input  logic [LVL_W:0]    rx_thr,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic [CNT_W-1:0]  moved,
    output buf_flags_t        flags,
    output logic [LVL_W-1:0]  drain_count
);
    logic [CNT_W-1:0] tx_fill_x, rx_fill_x, tx_thr_x, rx_thr_x, remain;

    assign tx_fill_x = CNT_W'(tx_fill);
    assign rx_fill_x = CNT_W'(rx_fill);
    assign tx_thr_x  = CNT_W'(tx_thr);
    assign rx_thr_x  = CNT_W'(rx_thr);
    assign remain    = (xfer_count > moved) ? (xfer_count - moved) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            drain_count <= '0;
        end else begin
            flags.rx_ready <= (rx_fill_x > rx_thr_x);
            if (!xmit_mode) begin
                flags.tx_ready <= 1'b0;
                flags.tx_drain <= 1'b0;
            end else if (tx_fill_x <= tx_thr_x) begin
                flags.tx_ready <= 1'b1;
                flags.tx_drain <= 1'b0;
            end else if (remain < tx_thr_x) begin
                flags.tx_ready <= 1'b0;
                flags.tx_drain <= 1'b1;
                drain_count    <= remain[LVL_W-1:0];
            end
        end
    end

    p_rx_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !xmit_mode |=> (!flags.tx_ready && !flags.tx_drain));
    p_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (xmit_mode && (tx_fill_x <= tx_thr_x)) |=> (flags.tx_ready && !flags.tx_drain));
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(flags.tx_ready && flags.tx_drain));
    p_rx_level_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_fill_x <= rx_thr_x) |=> !flags.rx_ready);
endmodule

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf
    import i2c_fifo_buf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              xmit_mode,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              cpu_push,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic              cpu_pop,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              eng_tx_req,
    output logic [BYTE_W-1:0] eng_tx_data,
    output logic              tx_avail,
    input  logic              eng_rx_valid,
    input  logic [BYTE_W-1:0] eng_rx_data,
    output logic              tx_ready,
    output logic              tx_drain,
    output logic              rx_ready,
    output logic [LVL_W-1:0]  drain_count,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tx_overflow,
    output logic              tx_underflow,
    output logic              rx_overrun
);
    buf_cfg_t         cfg_in;
    logic [LVL_W-1:0] tx_lvl_q, rx_lvl_q;
    logic             tx_dma_q, rx_dma_q, mode_q;
    logic             tx_flush, rx_flush;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [FW-1:0]    tx_fill, rx_fill;
    logic [CNT_W-1:0] moved;
    logic             tx_take;
    buf_flags_t       flags;

    assign cfg_in   = buf_cfg_t'(cfg_word);
    assign tx_flush = (cfg_wr && cfg_in.tx_clr) || (xmit_mode && !mode_q);
    assign rx_flush = (cfg_wr && cfg_in.rx_clr) || (!xmit_mode && mode_q);
    assign tx_take  = eng_tx_req && !tx_empty;
    assign tx_avail = !tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_lvl_q <= '0;
            rx_lvl_q <= '0;
            tx_dma_q <= 1'b0;
            rx_dma_q <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            mode_q <= xmit_mode;
            if (cfg_wr) begin
                tx_lvl_q <= cfg_in.tx_lvl;
                rx_lvl_q <= cfg_in.rx_lvl;
                tx_dma_q <= cfg_in.tx_dma;
                rx_dma_q <= cfg_in.rx_dma;
            end
        end
    end

    i2c_fifo_buf_queue #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(cpu_push), .din(cpu_wdata),
        .pop(eng_tx_req), .dout(eng_tx_data),
        .full(tx_full), .empty(tx_empty), .fill(tx_fill)
    );

    i2c_fifo_buf_queue #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(eng_rx_valid), .din(eng_rx_data),
        .pop(cpu_pop), .dout(cpu_rdata),
        .full(rx_full), .empty(rx_empty), .fill(rx_fill)
    );

    always_ff @(posedge clk) begin
        if (rst || tx_flush)  moved <= '0;
        else if (tx_take && moved != '1) moved <= moved + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_overflow  <= 1'b0;
            tx_underflow <= 1'b0;
            rx_overrun   <= 1'b0;
        end else begin
            if (tx_flush)
                tx_overflow <= 1'b0;
            else if (cpu_push && tx_full && !tx_take)
                tx_overflow <= 1'b1;

            if (cpu_push)
                tx_underflow <= 1'b0;
            else if (eng_tx_req && tx_empty)
                tx_underflow <= 1'b1;

            if (rx_flush || cpu_pop)
                rx_overrun <= 1'b0;
            else if (eng_rx_valid && rx_full)
                rx_overrun <= 1'b1;
        end
    end

    i2c_fifo_buf_status #(.FILL_W(FW), .CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst(rst), .xmit_mode(xmit_mode),
        .tx_fill(tx_fill), .rx_fill(rx_fill),
        .tx_thr(lvl_to_thr(tx_lvl_q)), .rx_thr(lvl_to_thr(rx_lvl_q)),
        .xfer_count(xfer_count), .moved(moved),
        .flags(flags), .drain_count(drain_count)
    );

    assign tx_ready   = flags.tx_ready;
    assign tx_drain   = flags.tx_drain;
    assign rx_ready   = flags.rx_ready;
    assign tx_dma_req = tx_dma_q && flags.tx_ready;
    assign rx_dma_req = rx_dma_q && flags.rx_ready;

    p_tx_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_word[6]) |=> (!tx_avail && !tx_overflow));
    p_rx_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_word[14]) |=> (rx_empty && !rx_overrun));
    p_mode_tx_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit_mode) |=> !tx_avail);
    p_underflow_r13: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_req && !tx_avail && !cpu_push) |=> tx_underflow);
    p_overrun_r12: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_valid && rx_full && !cpu_pop && !rx_flush) |=> rx_overrun);
    p_dma_off_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_dma_q |-> !tx_dma_req);
endmodule

// File: tb/i2c_fifo_buf_bench.sv
module i2c_fifo_buf_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        xmit_mode = 1'b0;
    logic [15:0] xfer_count = '0;
    logic        cpu_push = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_pop = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        eng_tx_req = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        tx_avail;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        tx_ready, tx_drain, rx_ready;
    logic [5:0]  drain_count;
    logic        tx_dma_req, rx_dma_req, tx_overflow, tx_underflow, rx_overrun;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    i2c_fifo_buf u_i2c_fifo_buf (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .xmit_mode(xmit_mode), .xfer_count(xfer_count),
        .cpu_push(cpu_push), .cpu_wdata(cpu_wdata),
        .cpu_pop(cpu_pop), .cpu_rdata(cpu_rdata),
        .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data), .tx_avail(tx_avail),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .tx_ready(tx_ready), .tx_drain(tx_drain), .rx_ready(rx_ready),
        .drain_count(drain_count), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_overflow(tx_overflow), .tx_underflow(tx_underflow), .rx_overrun(rx_overrun)
    );

    // bench model
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int m_thr_tx, m_thr_rx, m_cnt, m_moved, m_dc;
    bit m_mode, m_rdy, m_drn, m_ovf, m_udf, m_ovr;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_op();
        @(negedge clk);
        cfg_wr = 1'b0; cpu_push = 1'b0; cpu_pop = 1'b0;
        eng_tx_req = 1'b0; eng_rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_eval();
        int rem;
        if (!m_mode) begin
            m_rdy = 0; m_drn = 0;
        end else if (txq.size() <= m_thr_tx) begin
            m_rdy = 1; m_drn = 0;
        end else begin
            rem = (m_cnt > m_moved) ? m_cnt - m_moved : 0;
            if (rem < m_thr_tx) begin
                m_rdy = 0; m_drn = 1; m_dc = rem;
            end
        end
    endtask

    task automatic check_tx(input string tag);
        check({tag, " R5 tx_ready"}, int'(tx_ready), int'(m_rdy));
        check({tag, " R6 tx_drain"}, int'(tx_drain), int'(m_drn));
        if (m_drn) check({tag, " R6 drain_count"}, int'(drain_count), m_dc);
        check({tag, " R9 tx_dma_req"}, int'(tx_dma_req), int'(m_rdy));
        check({tag, " R11 tx_overflow"}, int'(tx_overflow), int'(m_ovf));
        check({tag, " R13 tx_underflow"}, int'(tx_underflow), int'(m_udf));
        check({tag, " R10 tx_avail"}, int'(tx_avail), int'(txq.size() != 0));
    endtask

    task automatic check_rx(input string tag);
        check({tag, " R8 rx_ready"}, int'(rx_ready), int'(rxq.size() > m_thr_rx));
        check({tag, " R9 rx_dma_req"}, int'(rx_dma_req), int'(rxq.size() > m_thr_rx));
        check({tag, " R12 rx_overrun"}, int'(rx_overrun), int'(m_ovr));
        check({tag, " R7 tx_ready"}, int'(tx_ready), 0);
        check({tag, " R7 tx_drain"}, int'(tx_drain), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnts[4];
        cnts[0] = 3; cnts[1] = 6; cnts[2] = 10; cnts[3] = 40;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_ready", int'(tx_ready), 0);
        check("R1 tx_drain", int'(tx_drain), 0);
        check("R1 rx_ready", int'(rx_ready), 0);
        check("R1 tx_avail", int'(tx_avail), 0);
        check("R1 dma", int'(tx_dma_req | rx_dma_req), 0);
        check("R1 errors", int'(tx_overflow | tx_underflow | rx_overrun), 0);

        m_mode = 1; m_ovf = 0; m_udf = 0; m_ovr = 0;
        m_thr_rx = 1; m_moved = 0; m_cnt = 0;
        xmit_mode = 1'b1;
        finish_op();

        // R2 R5 R6 R10 R11 R13 transmit sweep
        for (int tf = 0; tf < 8; tf++) begin
            for (int ci = 0; ci < 4; ci++) begin
                xfer_count = 16'(cnts[ci]);
                cfg_word = {1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 6'(tf)};
                cfg_wr = 1'b1;
                finish_op();
                m_thr_tx = tf + 1; m_cnt = cnts[ci]; m_moved = 0; m_ovf = 0;
                txq.delete();
                tx_eval();
                check_tx("R2 R3 cfg");
                for (int k = 0; k < 9; k++) begin
                    cpu_wdata = 8'((tf * 37 + ci * 11 + k * 5) & 255);
                    cpu_push = 1'b1;
                    if (txq.size() < 8) txq.push_back(cpu_wdata); else m_ovf = 1;
                    m_udf = 0;
                    finish_op();
                    tx_eval();
                    check_tx("push");
                end
                for (int k = 0; k < 9; k++) begin
                    if (txq.size() != 0)
                        check("R10 eng_tx_data", int'(eng_tx_data), int'(txq[0]));
                    eng_tx_req = 1'b1;
                    if (txq.size() != 0) begin
                        void'(txq.pop_front()); m_moved++;
                    end else m_udf = 1;
                    finish_op();
                    tx_eval();
                    check_tx("take");
                end
            end
        end

        // R7 R8 R12 receive sweep
        xmit_mode = 1'b0;
        finish_op();
        m_mode = 0; rxq.delete();
        for (int rf = 0; rf < 8; rf++) begin
            cfg_word = {1'b1, 1'b1, 6'(rf), 1'b0, 1'b0, 6'd0};
            cfg_wr = 1'b1;
            finish_op();
            m_thr_rx = rf + 1; m_ovr = 0; rxq.delete();
            check_rx("R2 R3 rxcfg");
            for (int k = 0; k < 9; k++) begin
                eng_rx_data = 8'((rf * 23 + k * 7 + 1) & 255);
                eng_rx_valid = 1'b1;
                if (rxq.size() < 8) rxq.push_back(eng_rx_data); else m_ovr = 1;
                finish_op();
                check_rx("arrive");
            end
            for (int k = 0; k < 9; k++) begin
                if (rxq.size() != 0)
                    check("R10 cpu_rdata", int'(cpu_rdata), int'(rxq[0]));
                cpu_pop = 1'b1;
                if (rxq.size() != 0) void'(rxq.pop_front());
                m_ovr = 0;
                finish_op();
                check_rx("pop");
            end
        end

        // R4 direction changes
        cfg_word = 16'h0000; cfg_wr = 1'b1; finish_op();
        for (int k = 0; k < 3; k++) begin
            eng_rx_data = 8'(k); eng_rx_valid = 1'b1; finish_op();
        end
        check("R8 rx_ready 3>1", int'(rx_ready), 1);
        xmit_mode = 1'b1; finish_op();
        check("R4 rx kept on tx select", int'(rx_ready), 1);
        check("R4 tx emptied", int'(tx_avail), 0);
        for (int k = 0; k < 2; k++) begin
            cpu_wdata = 8'(k + 9); cpu_push = 1'b1; finish_op();
        end
        check("R4 tx has bytes", int'(tx_avail), 1);
        xmit_mode = 1'b0; finish_op();
        check("R4 rx emptied on rx select", int'(rx_ready), 0);
        xmit_mode = 1'b1; finish_op();
        check("R4 tx emptied on tx select", int'(tx_avail), 0);

        // R13 underflow set and cleared
        eng_tx_req = 1'b1; finish_op();
        check("R13 underflow set", int'(tx_underflow), 1);
        check("R13 nothing taken", int'(tx_avail), 0);
        cpu_wdata = 8'hA5; cpu_push = 1'b1; finish_op();
        check("R13 underflow cleared", int'(tx_underflow), 0);
        check("R10 head byte", int'(eng_tx_data), 8'hA5);

        // R9 DMA disabled
        cfg_word = 16'h0000; cfg_wr = 1'b1; finish_op();
        check("R9 ready with dma off", int'(tx_ready), 1);
        check("R9 tx_dma_req off", int'(tx_dma_req), 0);
        check("R9 rx_dma_req off", int'(rx_dma_req), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule